// File: doc/BRIEF.md
# Speculative Branch Mask Tracker

This block keeps track of up to four conditional branches that are still unresolved in a superscalar pipeline. Each open branch owns one bit of a one-hot slot vector. Each instruction issued under speculation carries a 4-bit tag, and each set bit in that tag names one branch the instruction depends on. When issue presents a new branch, the block grants it the lowest free slot. The block also publishes the current dependency mask, which the issue logic copies into the tags of the instructions it sends out.

When a branch condition is known, the resolution port names the branch's slot and whether its prediction was wrong. For a wrong prediction, the block broadcasts a kill vector. That vector holds the branch's own bit and the bit of every branch issued after it, and all of those slots are freed in the same cycle. Any in-flight instruction whose tag meets the kill vector must be aborted. For a correct prediction, the block broadcasts a clear vector with the branch's bit. Holders of tags drop that bit, and the slot returns to the free pool. Work on the right path therefore keeps its results, and work on the wrong path is discarded.

A resolution in a cycle is applied before that cycle's allocation, so a slot freed in a cycle can be granted again in the same cycle. A stall output tells issue to hold the next branch while all four slots are in use. A small probe port applies the current broadcast to one tag, so that tag holders can share the update rule.

Top module: `spec_mask_tracker`

## Requirements
- R1: After reset no slot is in use: dep_mask is 0000, br_stall is 0, br_grant is 0000, and kill_vec and clear_vec are 0000.
- R2: When br_req is 1 and br_stall is 0, br_grant is the one-hot bit of the lowest-numbered free slot (bit 0 is slot 0) after this cycle's resolution. Otherwise br_grant is 0000.
- R3: dep_mask equals the set of outstanding slots after this cycle's resolution is applied. In the next cycle that set also holds the bit granted in this cycle.
- R4: br_stall is 1 exactly when all four slots are outstanding after this cycle's resolution. While br_stall is 1, a request gets no grant and the outstanding set does not change.
- R5: A resolution with rsv_wrong at 0 for an outstanding slot sets clear_vec to that slot's bit and kill_vec to 0000, and frees the slot.
- R6: A resolution with rsv_wrong at 1 for an outstanding slot sets kill_vec to that slot's bit plus the bits of all outstanding slots granted later, and clear_vec to 0000. All those slots are freed in the same cycle, and slots granted earlier stay outstanding.
- R7: A resolution and a request in the same cycle act as if the resolution came first: a slot freed in that cycle can be granted in that cycle, even when all four slots were in use before it.
- R8: A resolution that names a slot that is not outstanding is ignored: kill_vec and clear_vec stay 0000 and the outstanding set does not change.
- R9: probe_abort is 1 when probe_tag shares a bit with kill_vec. probe_tag_next is probe_tag with every bit of kill_vec and clear_vec removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_req | input | 1 | Issue wants a slot for a new branch |
| br_stall | output | 1 | All slots are in use, so the next branch must wait |
| br_grant | output | 4 | One-hot slot granted to the new branch |
| dep_mask | output | 4 | Tag for instructions issued in this cycle |
| rsv_valid | input | 1 | A branch outcome is presented |
| rsv_slot | input | 4 | One-hot slot of the resolved branch |
| rsv_wrong | input | 1 | The resolved branch was mispredicted |
| kill_vec | output | 4 | Slots whose dependents must be aborted |
| clear_vec | output | 4 | Slot to drop from tags after a correct prediction |
| probe_tag | input | 4 | A tag to which the current broadcast is applied |
| probe_abort | output | 1 | The probed tag meets the kill vector |
| probe_tag_next | output | 4 | The probed tag after the broadcast |

## Verification
A wrong outstanding set shows on dep_mask and br_stall in the same cycle and on br_grant at the next request. A wrong age record shows up only when a branch is mispredicted, as a kill vector that takes too many or too few slots. For that reason the sweeps grant slots again in shuffled orders after partial frees, and then mispredict branches at every position in the age order. A stale age bit left behind by a freed slot is the subtle case: it is caught when a slot is granted again and then killed while an older branch stays outstanding.

// File: rtl/spec_mask_tracker.sv
module spec_mask_tracker #(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_req,
  output logic             br_stall,
  output logic [SLOTS-1:0] br_grant,
  output logic [SLOTS-1:0] dep_mask,
  input  logic             rsv_valid,
  input  logic [SLOTS-1:0] rsv_slot,
  input  logic             rsv_wrong,
  output logic [SLOTS-1:0] kill_vec,
  output logic [SLOTS-1:0] clear_vec,
  input  logic [SLOTS-1:0] probe_tag,
  output logic             probe_abort,
  output logic [SLOTS-1:0] probe_tag_next
);

  logic [SLOTS-1:0] live_q;
  logic [SLOTS-1:0] older_q [SLOTS];
  logic [SLOTS-1:0] hit, younger, after, free;

  assign hit = rsv_valid ? (rsv_slot & live_q) : '0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_age
    assign younger[i] = live_q[i] & |(older_q[i] & hit);
  end

  assign kill_vec  = rsv_wrong ? (hit | younger) : '0;
  assign clear_vec = rsv_wrong ? '0 : hit;
  assign after     = live_q & ~kill_vec & ~clear_vec;
  assign free      = ~after;
  assign br_stall  = &after;
  assign br_grant  = (br_req && !br_stall) ? (free & (~free + 1'b1)) : '0;
  assign dep_mask  = after;

  assign probe_abort    = |(probe_tag & kill_vec);
  assign probe_tag_next = probe_tag & ~kill_vec & ~clear_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      for (int i = 0; i < SLOTS; i++) older_q[i] <= '0;
    end else begin
      live_q <= after | br_grant;
      for (int i = 0; i < SLOTS; i++)
        older_q[i] <= br_grant[i] ? after : (older_q[i] & after);
    end
  end

endmodule

module spec_mask_tracker_chk #(
  parameter int SLOTS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_stall,
  input logic [SLOTS-1:0] br_grant,
  input logic [SLOTS-1:0] dep_mask,
  input logic             rsv_valid,
  input logic [SLOTS-1:0] rsv_slot,
  input logic             rsv_wrong,
  input logic [SLOTS-1:0] kill_vec,
  input logic [SLOTS-1:0] clear_vec,
  input logic [SLOTS-1:0] live_q
);

  // R2
  grant_lowest_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_grant) && ((br_grant & dep_mask) == '0));

  // R4
  stall_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_stall |-> (br_grant == '0));

  // R3
  live_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (live_q == $past(dep_mask | br_grant)));

  // R5
  correct_no_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && !rsv_wrong) |-> (kill_vec == '0));

  // R6
  killed_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_vec != '0) |=> ((live_q & $past(kill_vec & ~br_grant)) == '0));

  // R8
  stale_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && ((rsv_slot & live_q) == '0)) |-> ((kill_vec | clear_vec) == '0));

endmodule

bind spec_mask_tracker spec_mask_tracker_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_stall(br_stall), .br_grant(br_grant),
  .dep_mask(dep_mask), .rsv_valid(rsv_valid), .rsv_slot(rsv_slot),
  .rsv_wrong(rsv_wrong), .kill_vec(kill_vec), .clear_vec(clear_vec),
  .live_q(live_q)
);

// File: tb/spec_mask_tracker_test.sv
module spec_mask_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_req = 1'b0, rsv_valid = 1'b0, rsv_wrong = 1'b0;
  logic [3:0] rsv_slot = '0, probe_tag = '0;
  logic br_stall, probe_abort;
  logic [3:0] br_grant, dep_mask, kill_vec, clear_vec, probe_tag_next;

  int n_chk = 0, n_err = 0;
  logic [3:0] m_live = '0;
  int m_seq [4];
  int m_cnt = 0;

  always #4 clk = ~clk;

  spec_mask_tracker uut (
    .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_stall(br_stall),
    .br_grant(br_grant), .dep_mask(dep_mask), .rsv_valid(rsv_valid),
    .rsv_slot(rsv_slot), .rsv_wrong(rsv_wrong), .kill_vec(kill_vec),
    .clear_vec(clear_vec), .probe_tag(probe_tag), .probe_abort(probe_abort),
    .probe_tag_next(probe_tag_next)
  );

  task automatic chk(string r, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic step(input bit req, input bit rv, input logic [3:0] rs,
                      input bit wr, input logic [3:0] pt);
    logic [3:0] e_kill, e_clear, e_after, e_grant;
    int idx;
    @(negedge clk);
    br_req = req; rsv_valid = rv; rsv_slot = rs; rsv_wrong = wr; probe_tag = pt;
    #2;
    e_kill = '0; e_clear = '0; idx = -1;
    for (int i = 0; i < 4; i++) if (rv && rs[i] && m_live[i]) idx = i;
    if (idx >= 0) begin
      if (wr) begin
        for (int i = 0; i < 4; i++)
          if (m_live[i] && m_seq[i] >= m_seq[idx]) e_kill[i] = 1'b1;
      end else e_clear[idx] = 1'b1;
    end
    e_after = m_live & ~e_kill & ~e_clear;
    e_grant = '0;
    if (req && e_after != 4'hF)
      for (int i = 3; i >= 0; i--) if (!e_after[i]) e_grant = 4'(1 << i);
    chk("R6 kill_vec", kill_vec, e_kill);
    chk("R5 clear_vec", clear_vec, e_clear);
    chk("R3 dep_mask", dep_mask, e_after);
    chk("R4 br_stall", {3'b0, br_stall}, {3'b0, e_after == 4'hF});
    chk("R2 br_grant", br_grant, e_grant);
    chk("R9 probe_abort", {3'b0, probe_abort}, {3'b0, (pt & e_kill) != 0});
    chk("R9 probe_tag_next", probe_tag_next, pt & ~e_kill & ~e_clear);
    @(posedge clk);
    for (int i = 0; i < 4; i++) if (e_grant[i]) m_seq[i] = m_cnt++;
    m_live = e_after | e_grant;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_seq[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 dep_mask", dep_mask, 4'h0);
    chk("R1 br_stall", {3'b0, br_stall}, 4'h0);
    chk("R1 kill_clear", kill_vec | clear_vec, 4'h0);
    chk("R1 br_grant", br_grant, 4'h0);

    for (int k = 0; k < 4; k++) step(1, 0, 4'h0, 0, 4'h0);
    step(1, 0, 4'h0, 0, 4'h0);
    chk("R4 full hold", dep_mask, 4'hF);
    step(1, 1, 4'b0100, 0, 4'b0110);
    chk("R7 reuse grant", br_grant, 4'b0100);
    step(0, 1, 4'b0010, 1, 4'b1000);
    chk("R6 kill younger", kill_vec, 4'b1110);
    step(0, 1, 4'b1000, 0, 4'hF);
    chk("R8 ignored", kill_vec | clear_vec, 4'h0);
    chk("R8 live kept", dep_mask, 4'b0001);

    for (int k = 0; k < 6000; k++) begin
      logic [3:0] rs;
      rs = 4'(1 << $urandom_range(0, 3));
      step(($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 4), rs,
           $urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)));
    end

    step(0, 0, 4'h0, 0, 4'h0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule